// File: doc/BRIEF.md
# Per-Channel Colour Prescale Stage

This block sits at the front of a display colour pipe. Each pixel carries red, green and blue samples. Each of the three channels is multiplied by its own unsigned fixed-point gain and then offset by its own signed bias. The result is saturated to the pixel range and registered. A control bit lets pixels through untouched. The inverse of that bit is driven out as a select that tells a downstream legacy lookup table to step aside while the prescale path is in use.

Software programs the stage through a small write-only register port. Address 0 is control. Addresses 1, 2 and 3 hold the red, green and blue gain/bias words. Every coefficient write lands in a staging copy first. The copy the arithmetic uses is refreshed from staging in two cases: on every clock while the bypass bit is set, and on a frame-start pulse. A frame therefore never sees a mix of old and new coefficients. The safe programming order is to set bypass, write the coefficients, then clear bypass.

Top module: `color_prescale`

## Requirements
- R1: After reset, out_valid is 0, all three output samples are 0, bypass is set and lut_bypass is 0. Every channel holds gain 1.0 (0x4000) and bias 0, so clearing bypass without writing coefficients gives output equal to input.
- R2: out_valid is in_valid delayed by exactly one clock. The output samples change only in the cycle after a valid input and hold their value otherwise.
- R3: When the bypass bit is 1 in the cycle a pixel is accepted, each output sample equals its input sample.
- R4: When bypass is 0, each channel outputs floor(in × gain / 2^14) + bias, using that channel's own word. The word layout is: gain is an unsigned 2.14 value in wr_data[15:0], and bias is a signed two's-complement value in pixel LSBs in wr_data[27:16]. The word for red is at address 1, green at address 2 and blue at address 3.
- R5: A negative result of the R4 formula is output as 0.
- R6: A result of the R4 formula above 2^PIX_W − 1 is output as 2^PIX_W − 1.
- R7: Writing address 0 sets bypass to wr_data[0]. lut_bypass equals the inverse of bypass and changes in the cycle after the write.
- R8: While bypass is 0, a coefficient write does not change the arithmetic until a frame_start pulse. If the write and frame_start fall in the same cycle, that pulse applies the previous staged value and the next pulse applies the new one.
- R9: Coefficients written while bypass is 1 are in effect for the first pixel after bypass is cleared, with no frame_start needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that commits staged coefficients |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 red, 2 green, 3 blue |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | PIX_W | Input red sample |
| in_g | input | PIX_W | Input green sample |
| in_b | input | PIX_W | Input blue sample |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | PIX_W | Output red sample |
| out_g | output | PIX_W | Output green sample |
| out_b | output | PIX_W | Output blue sample |
| lut_bypass | output | 1 | High while the prescale path is active, telling the legacy lookup table to pass through |

## Verification
The bench targets commit timing. Three cases are covered: a write made with bypass clear and held back until frame_start, a write that coincides with frame_start, and a write staged under bypass that must be live as soon as bypass drops. A design that loaded active coefficients on every write would change a pixel mid-frame. A design that committed only on frame_start would apply stale gains after bypass is released. Saturation is exercised at both ends: a large negative bias and a near-4.0 gain. Wrapping instead of clamping shows up as a small or wrong output sample. Giving one channel another channel's word shows up because the three channels use distinct gains and biases.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int NUM_CH = 3;
  localparam int REG_W  = 32;
  localparam int CTRL_BYPASS_BIT = 0;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_RED   = 2'd1,
    ADDR_GREEN = 2'd2,
    ADDR_BLUE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/prescale_coef_bank.sv
module prescale_coef_bank
  import prescale_pkg::*;
#(
  parameter int SCALE_W = 16,
  parameter int BIAS_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [REG_W-1:0]            wr_data,
  input  logic                        bypass,
  input  logic                        frame_start,
  output logic [NUM_CH*SCALE_W-1:0]   act_scale_flat,
  output logic [NUM_CH*BIAS_W-1:0]    act_bias_flat
);
  localparam int FRAC = SCALE_W - 2;
  localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1) << FRAC;

  // commit staged values while bypassed or at a frame boundary
  logic commit;
  assign commit = bypass | frame_start;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ch + 1);
    logic [SCALE_W-1:0] stg_scale, act_scale;
    logic [BIAS_W-1:0]  stg_bias,  act_bias;
    logic               hit;

    assign hit = wr_en && (wr_addr == MY_ADDR);

    always_ff @(posedge clk) begin
      if (rst) begin
        stg_scale <= UNITY;
        stg_bias  <= '0;
        act_scale <= UNITY;
        act_bias  <= '0;
      end else begin
        if (hit) begin
          stg_scale <= wr_data[SCALE_W-1:0];
          stg_bias  <= wr_data[SCALE_W +: BIAS_W];
        end
        if (commit) begin
          act_scale <= stg_scale;
          act_bias  <= stg_bias;
        end
      end
    end

    assign act_scale_flat[ch*SCALE_W +: SCALE_W] = act_scale;
    assign act_bias_flat[ch*BIAS_W +: BIAS_W]    = act_bias;
  end
endmodule

// File: rtl/prescale_lane.sv
module prescale_lane #(
  parameter int PIX_W   = 10,
  parameter int SCALE_W = 16,
  parameter int BIAS_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               bypass,
  input  logic [PIX_W-1:0]   pix_in,
  input  logic [SCALE_W-1:0] scale,
  input  logic [BIAS_W-1:0]  bias,
  output logic [PIX_W-1:0]   pix_out
);
  localparam int FRAC   = SCALE_W - 2;
  localparam int PROD_W = PIX_W + SCALE_W;
  localparam int SHR_W  = PROD_W - FRAC;
  localparam int SUM_W  = PIX_W + BIAS_W + 2;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic [PROD_W-1:0] prod;
  logic [SHR_W-1:0]  shifted;
  logic [SUM_W-1:0]  sum;
  logic [PIX_W-1:0]  sat;

  always_comb begin
    prod    = PROD_W'(pix_in) * PROD_W'(scale);
    shifted = prod[PROD_W-1:FRAC];
    sum     = {{(SUM_W-SHR_W){1'b0}}, shifted}
            + {{(SUM_W-BIAS_W){bias[BIAS_W-1]}}, bias};
    if (sum[SUM_W-1])
      sat = '0;
    else if (|sum[SUM_W-2:PIX_W])
      sat = PIX_MAX;
    else
      sat = sum[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      pix_out <= '0;
    else if (in_valid)
      pix_out <= bypass ? pix_in : sat;
  end
endmodule

// File: rtl/color_prescale.sv
module color_prescale
  import prescale_pkg::*;
#(
  parameter int PIX_W   = 10,
  parameter int SCALE_W = 16,
  parameter int BIAS_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b,
  output logic             lut_bypass
);
  logic                      bypass_q;
  logic [NUM_CH*SCALE_W-1:0] act_scale_flat;
  logic [NUM_CH*BIAS_W-1:0]  act_bias_flat;
  logic [PIX_W-1:0]          pin  [NUM_CH];
  logic [PIX_W-1:0]          pout [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      bypass_q  <= 1'b1;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (wr_en && (wr_addr == ADDR_CTRL))
        bypass_q <= wr_data[CTRL_BYPASS_BIT];
    end
  end

  assign lut_bypass = ~bypass_q;

  prescale_coef_bank #(.SCALE_W(SCALE_W), .BIAS_W(BIAS_W)) i_bank (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .bypass         (bypass_q),
    .frame_start    (frame_start),
    .act_scale_flat (act_scale_flat),
    .act_bias_flat  (act_bias_flat)
  );

  assign pin[0] = in_r;
  assign pin[1] = in_g;
  assign pin[2] = in_b;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    prescale_lane #(.PIX_W(PIX_W), .SCALE_W(SCALE_W), .BIAS_W(BIAS_W)) i_lane (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .bypass   (bypass_q),
      .pix_in   (pin[ch]),
      .scale    (act_scale_flat[ch*SCALE_W +: SCALE_W]),
      .bias     (act_bias_flat[ch*BIAS_W +: BIAS_W]),
      .pix_out  (pout[ch])
    );
  end

  assign out_r = pout[0];
  assign out_g = pout[1];
  assign out_b = pout[2];
endmodule

// File: rtl/prescale_checker.sv
module prescale_checker #(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 84
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic              in_valid,
  input logic [PIX_W-1:0]  in_r,
  input logic [PIX_W-1:0]  in_g,
  input logic [PIX_W-1:0]  in_b,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_r,
  input logic [PIX_W-1:0]  out_g,
  input logic [PIX_W-1:0]  out_b,
  input logic              lut_bypass,
  input logic              bypass_q,
  input logic [COEF_W-1:0] coef_live
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R2
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bypass_q) |=> (out_r == $past(in_r) && out_g == $past(in_g)
                                && out_b == $past(in_b))); // R3
  AST_LUT_SELECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> (lut_bypass == !$past(wr_data[0]))); // R7
  AST_COEF_HELD: assert property (@(posedge clk) disable iff (rst)
    (!bypass_q && !frame_start) |=> $stable(coef_live)); // R8
endmodule

bind color_prescale prescale_checker #(
  .PIX_W  (PIX_W),
  .COEF_W (prescale_pkg::NUM_CH * (SCALE_W + BIAS_W))
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .in_valid    (in_valid),
  .in_r        (in_r),
  .in_g        (in_g),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_r       (out_r),
  .out_g       (out_g),
  .out_b       (out_b),
  .lut_bypass  (lut_bypass),
  .bypass_q    (bypass_q),
  .coef_live   ({act_bias_flat, act_scale_flat})
);

// File: tb/test_color_prescale.sv
`timescale 1ns/1ps
module test_color_prescale;
  localparam int PIX_W = 10;
  localparam int PMAX  = (1 << PIX_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             frame_start = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic             in_valid = 1'b0;
  logic [PIX_W-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic             out_valid, lut_bypass;
  logic [PIX_W-1:0] out_r, out_g, out_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  always #10 clk = ~clk;

  color_prescale #(.PIX_W(PIX_W)) i_color_prescale (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .lut_bypass(lut_bypass)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  s_scale[3], s_bias[3], a_scale[3], a_bias[3];
  int  e_pix[3], e_raw[3];
  bit  m_byp, e_valid, e_byp;

  function automatic int in_of(int ch);
    return (ch == 0) ? int'(in_r) : (ch == 1) ? int'(in_g) : int'(in_b);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 3; c++) begin
        s_scale[c] = 16384; a_scale[c] = 16384;
        s_bias[c] = 0; a_bias[c] = 0; e_pix[c] = 0; e_raw[c] = 0;
      end
      m_byp = 1'b1; e_valid = 1'b0; e_byp = 1'b1;
    end else begin
      e_valid = in_valid;
      if (in_valid) begin
        e_byp = m_byp;
        for (int c = 0; c < 3; c++) begin
          int raw;
          raw = ((in_of(c) * a_scale[c]) / 16384) + a_bias[c];
          e_raw[c] = m_byp ? in_of(c) : raw;
          e_pix[c] = m_byp ? in_of(c) : (raw < 0 ? 0 : (raw > PMAX ? PMAX : raw));
        end
      end
      if (m_byp || frame_start)
        for (int c = 0; c < 3; c++) begin
          a_scale[c] = s_scale[c]; a_bias[c] = s_bias[c];
        end
      if (wr_en && wr_addr != 0) begin
        int bv;
        bv = int'(wr_data[27:16]);
        if (bv >= 2048) bv -= 4096;
        s_scale[wr_addr-1] = int'(wr_data[15:0]);
        s_bias[wr_addr-1]  = bv;
      end
      if (wr_en && wr_addr == 0) m_byp = wr_data[0];
    end
  end

  function automatic string tag_of(int c);
    if (e_byp) return "R3";
    if (e_raw[c] < 0) return "R5";
    if (e_raw[c] > PMAX) return "R6";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (live && !rst) begin
      chk("R2 valid", int'(out_valid), int'(e_valid));
      chk("R7 lut", int'(lut_bypass), int'(!m_byp));
      chk({tag_of(0), " red"},   int'(out_r), e_pix[0]);
      chk({tag_of(1), " green"}, int'(out_g), e_pix[1]);
      chk({tag_of(2), " blue"},  int'(out_b), e_pix[2]);
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] cw(int scale, int bias);
    return {4'h0, 12'(bias), 16'(scale)};
  endfunction

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_fs(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d; frame_start = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; frame_start = 1'b0;
  endtask

  task automatic fs();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pix(int r, int g, int b);
    in_valid = 1'b1; in_r = PIX_W'(r); in_g = PIX_W'(g); in_b = PIX_W'(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;
    // R1: reset state
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 red", int'(out_r), 0);
    chk("R1 lut", int'(lut_bypass), 0);
    wr(0, 32'd0);
    pix(7, 8, 9);
    chk("R1 identity red", int'(out_r), 7);
    chk("R1 identity blue", int'(out_b), 9);
    wr(0, 32'd1);

    // R3: pass-through
    pix(100, 200, 300);
    chk("R3 green", int'(out_g), 200);

    // R9: stage under bypass then release
    wr(1, cw(32768, 5));
    wr(2, cw(8192, -3));
    wr(3, cw(16384, 0));
    wr(0, 32'd0);
    chk("R7 lut after clear", int'(lut_bypass), 1);
    pix(100, 200, 300);
    chk("R9 red", int'(out_r), 205);
    chk("R9 green", int'(out_g), 97);
    chk("R4 blue", int'(out_b), 300);

    // R8: held until frame_start
    wr(1, cw(16384, 0));
    pix(100, 200, 300);
    chk("R8 held red", int'(out_r), 205);
    fs();
    pix(100, 200, 300);
    chk("R8 committed red", int'(out_r), 100);
    wr_fs(1, cw(16384, 50));
    pix(100, 200, 300);
    chk("R8 same-cycle red", int'(out_r), 100);
    fs();
    pix(100, 200, 300);
    chk("R8 next pulse red", int'(out_r), 150);

    // R5 / R6: saturation
    wr(2, cw(16384, -600));
    wr(1, cw(65535, 0));
    fs();
    pix(1000, 200, 300);
    chk("R5 green low", int'(out_g), 0);
    chk("R6 red high", int'(out_r), PMAX);
    @(negedge clk);
    chk("R2 hold red", int'(out_r), PMAX);

    // R7 / R3: back to bypass
    wr(0, 32'd1);
    chk("R7 lut after set", int'(lut_bypass), 0);
    pix(1000, 5, 1023);
    chk("R3 red", int'(out_r), 1000);
    chk("R3 blue", int'(out_b), 1023);

    // mixed traffic against the reference
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = nxt();
      in_valid    = (r[1:0] != 2'd0);
      in_r        = PIX_W'(nxt());
      in_g        = PIX_W'(nxt());
      in_b        = PIX_W'(nxt());
      frame_start = (r[6:4] == 3'd0);
      wr_en       = (r[9:7] == 3'd0);
      wr_addr     = 2'(r[11:10]);
      wr_data     = {4'h0, 12'(nxt() % 1400) - 12'd700, 16'(nxt())};
      if (r[11:10] == 2'd0) wr_data[0] = r[12];
      @(negedge clk);
    end
    in_valid = 1'b0; wr_en = 1'b0; frame_start = 1'b0;
    repeat (2) @(negedge clk);
    live = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule